// File: doc/BRIEF.md
# I2C Master Byte Engine

This block moves single bytes across a two-wire serial bus as the data phase of a bus master. A CPU-side write strobe hands it a byte (an address or data) to shift out on SDA. The block then samples the slave's acknowledge in a ninth clock. A receive-enable strobe makes it clock eight bits in from the slave and place them in a one-byte holding buffer. Bus start, stop, repeated start and the master's own acknowledge are handled elsewhere.

Both bus lines are open-drain. The block only pulls a line low or lets it go, and it reads SDA back. A reload counter of `HALF_CYC` system clocks sets the length of each SCL half-period. When a byte finishes, the engine raises its interrupt flag, holds SCL low and leaves SDA released. It stays like that until software issues the next command, so the bus is stalled between bytes. Five status outputs report the engine's state: buffer-full, write-collision, receive-overflow, acknowledge-status and interrupt. Buffer-full means "byte waiting to go out" while transmitting, and "received byte not yet read" while receiving.

Top module: `i2c_byte_engine`

## Requirements
- R1: While `rst_n` is low at a clock edge, the engine resets. After reset `scl_lo`, `sda_lo`, `buf_full`, `wcol`, `ovf`, `ack_stat`, `irq` and `rx_en` are all 0 and the engine is idle.
- R2: A `wr_stb` pulse while idle has the following effects from the next cycle:
  - `buf_full` is 1 and `scl_lo` is 1.
  - Nine SCL pulses follow.
  - Between pulses, each low phase lasts exactly `HALF_CYC` cycles. Each high phase also lasts exactly `HALF_CYC` cycles.
- R3: Transmitted bits leave most significant bit first, one per SCL pulse. `sda_lo` changes only in a cycle where `scl_lo` was already 1 in the cycle before, so SDA never moves while SCL is released.
- R4: `buf_full` drops to 0 at the falling edge that ends the eighth pulse. SDA is released (`sda_lo` = 0) for the whole ninth pulse.
- R5: `ack_stat` takes the SDA level sampled during the ninth pulse. It becomes 0 when the slave pulls SDA low (acknowledge) and 1 when SDA is high (no acknowledge).
- R6: When a byte completes, the engine does the following:
  - It sets `irq` and returns to idle.
  - It keeps `scl_lo` = 1 and `sda_lo` = 0.
  - It produces no further SCL pulse until the next command.
- R7: A `wr_stb` while a transmit or receive is in progress sets `wcol` and leaves `rd_data` unchanged. `wcol` stays 1 until a `clr_wcol` pulse.
- R8: An `rx_go` pulse while idle (and without `wr_stb`) starts a receive, as follows:
  - `rx_en` is 1 from the next cycle, and eight SCL pulses follow.
  - SDA is sampled MSB first just after each rising edge.
  - At the eighth falling edge, `rx_en` returns to 0, `rd_data` holds the received byte, and `buf_full` and `irq` are set.
- R9: Outside a transmit, an `rd_stb` pulse clears `buf_full`.
- R10: If a receive completes while `buf_full` is still 1, `ovf` is set. `ovf` stays 1 until a `clr_ovf` pulse.
- R11: `rx_go` while a transfer is in progress is ignored. `rx_en` stays 0 during a transmit, and the pulse count is unchanged.
- R12: A `clr_irq` pulse clears `irq` when no byte completes in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_stb | input | 1 | Buffer write strobe; starts a transmit when idle |
| wr_data | input | 8 | Byte written with `wr_stb` |
| rd_stb | input | 1 | Buffer read strobe |
| rx_go | input | 1 | Receive-enable strobe |
| clr_wcol | input | 1 | Clears the write-collision flag |
| clr_ovf | input | 1 | Clears the overflow flag |
| clr_irq | input | 1 | Clears the interrupt flag |
| sda_in | input | 1 | Sampled level of the SDA line |
| scl_lo | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_lo | output | 1 | 1 pulls SDA low, 0 releases it |
| rd_data | output | 8 | Holding buffer contents |
| buf_full | output | 1 | Buffer-full flag |
| wcol | output | 1 | Write-collision flag |
| ovf | output | 1 | Receive-overflow flag |
| ack_stat | output | 1 | Acknowledge status of the last transmitted byte |
| irq | output | 1 | Byte-complete interrupt flag |
| rx_en | output | 1 | Receive in progress |

## Verification
The properties assume that SCL is never stretched, so the line follows `scl_lo` exactly. They also assume the slave changes SDA only while SCL is held low. The bench slave model therefore updates its SDA drive only on the cycle after it sees an SCL falling edge, and it preloads the first receive bit before `rx_go`. Command strobes are single-cycle pulses applied between clock edges. The random mix of transmits, receives, acknowledge levels, early buffer reads and flag clears stays inside those limits.

// File: rtl/i2c_byte_engine.sv
module i2c_byte_engine #(
  parameter int unsigned HALF_CYC = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_stb,
  input  logic [7:0] wr_data,
  input  logic       rd_stb,
  input  logic       rx_go,
  input  logic       clr_wcol,
  input  logic       clr_ovf,
  input  logic       clr_irq,
  input  logic       sda_in,
  output logic       scl_lo,
  output logic       sda_lo,
  output logic [7:0] rd_data,
  output logic       buf_full,
  output logic       wcol,
  output logic       ovf,
  output logic       ack_stat,
  output logic       irq,
  output logic       rx_en
);
  localparam int unsigned CW = (HALF_CYC < 2) ? 1 : $clog2(HALF_CYC);
  localparam logic [CW-1:0] RELOAD = CW'(HALF_CYC - 1);

  typedef enum logic [1:0] {S_IDLE, S_TX, S_RX} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic          hi;
  logic [3:0]    bitn;
  logic [7:0]    dbuf, shreg;

  logic busy, tick, rise_now, fall_now, after_fall, after_rise, last, done;
  logic start_tx, start_rx;

  assign busy       = (st != S_IDLE);
  assign tick       = (cnt == '0);
  assign rise_now   = busy && tick && !hi;
  assign fall_now   = busy && tick && hi;
  assign after_fall = busy && !hi && (cnt == RELOAD);
  assign after_rise = busy && hi && (cnt == RELOAD);
  assign last       = (st == S_TX) ? (bitn == 4'd8) : (bitn == 4'd7);
  assign done       = fall_now && last;
  assign start_tx   = wr_stb && !busy;
  assign start_rx   = rx_go && !wr_stb && !busy;
  assign rd_data    = dbuf;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= RELOAD;
      hi       <= 1'b0;
      bitn     <= '0;
      dbuf     <= '0;
      shreg    <= '0;
      scl_lo   <= 1'b0;
      sda_lo   <= 1'b0;
      buf_full <= 1'b0;
      wcol     <= 1'b0;
      ovf      <= 1'b0;
      ack_stat <= 1'b0;
      irq      <= 1'b0;
      rx_en    <= 1'b0;
    end else begin
      if (clr_wcol) wcol <= 1'b0;
      if (clr_ovf)  ovf  <= 1'b0;
      if (clr_irq)  irq  <= 1'b0;
      if (rd_stb && st != S_TX) buf_full <= 1'b0;

      if (busy) begin
        cnt <= tick ? RELOAD : cnt - 1'b1;
        if (tick) hi <= !hi;
      end

      if (rise_now) scl_lo <= 1'b0;

      if (after_fall && st == S_TX)
        sda_lo <= (bitn < 4'd8) ? ~dbuf[~bitn[2:0]] : 1'b0;

      if (after_rise) begin
        if (st == S_RX) shreg <= {shreg[6:0], sda_in};
        if (st == S_TX && bitn == 4'd8) ack_stat <= sda_in;
      end

      if (fall_now) begin
        scl_lo <= 1'b1;
        bitn   <= bitn + 1'b1;
        if (st == S_TX && bitn == 4'd7) buf_full <= 1'b0;
      end

      if (done) begin
        st  <= S_IDLE;
        irq <= 1'b1;
        if (st == S_RX) begin
          rx_en    <= 1'b0;
          dbuf     <= shreg;
          buf_full <= 1'b1;
          if (buf_full) ovf <= 1'b1;
        end
      end

      if (wr_stb && busy) wcol <= 1'b1;

      if (start_tx) begin
        st       <= S_TX;
        dbuf     <= wr_data;
        buf_full <= 1'b1;
      end
      if (start_rx) begin
        st     <= S_RX;
        rx_en  <= 1'b1;
        sda_lo <= 1'b0;
      end
      if (start_tx || start_rx) begin
        scl_lo <= 1'b1;
        hi     <= 1'b0;
        bitn   <= '0;
        cnt    <= RELOAD;
      end
    end
  end
endmodule

// File: rtl/i2c_byte_engine_chk.sv
module i2c_byte_engine_chk (
  input logic clk,
  input logic rst_n,
  input logic wr_stb,
  input logic rx_go,
  input logic clr_wcol,
  input logic clr_ovf,
  input logic scl_lo,
  input logic sda_lo,
  input logic buf_full,
  input logic wcol,
  input logic ovf,
  input logic irq,
  input logic rx_en,
  input logic busy
);
  p_write_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb && !busy |=> buf_full && scl_lo && busy);

  p_sda_in_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_lo) |-> scl_lo && $past(scl_lo));

  p_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> scl_lo && !sda_lo && irq);

  p_wcol_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wcol && !clr_wcol |=> wcol);

  p_collide_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb && busy |=> wcol);

  p_rx_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_en) |-> buf_full && irq && !busy);

  p_ovf_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ovf && !clr_ovf |=> ovf);

  p_rx_ignore_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rx_go && busy && !rx_en |=> !rx_en);
endmodule

bind i2c_byte_engine i2c_byte_engine_chk u_chk (.*);

// File: tb/test_i2c_byte_engine.sv
`timescale 1ns/1ps
module test_i2c_byte_engine;
  localparam int H = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_stb = 0, rd_stb = 0, rx_go = 0, clr_wcol = 0, clr_ovf = 0, clr_irq = 0;
  logic [7:0] wr_data = 0;
  logic scl_lo, sda_lo, buf_full, wcol, ovf, ack_stat, irq, rx_en;
  logic [7:0] rd_data;
  logic slave_low = 0;
  logic sda_in;

  int checks = 0, errors = 0;

  assign sda_in = ~(sda_lo | slave_low);
  always #10 clk = ~clk;

  i2c_byte_engine #(.HALF_CYC(H)) i_i2c_byte_engine (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_data(wr_data), .rd_stb(rd_stb),
    .rx_go(rx_go), .clr_wcol(clr_wcol), .clr_ovf(clr_ovf), .clr_irq(clr_irq),
    .sda_in(sda_in), .scl_lo(scl_lo), .sda_lo(sda_lo), .rd_data(rd_data),
    .buf_full(buf_full), .wcol(wcol), .ovf(ovf), .ack_stat(ack_stat), .irq(irq),
    .rx_en(rx_en));

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // bus monitor and slave model
  int rises = 0, base = 0, lo_len = 0, hi_len = 0, bf_drop_rel = -1;
  bit p_scl = 0, p_sda = 0, bf_p = 0, in_hi = 0, bf_drop_scl = 0;
  bit mode_rx = 0, ack_low = 0;
  logic [7:0] rx_byte = 0;
  logic bits [0:15];

  always @(negedge clk) if (rst_n) begin
    int rel;
    rel = rises - base;
    if (sda_lo != p_sda)
      check(scl_lo && p_scl, "R3", "SDA changed outside SCL low", int'(sda_lo), int'(p_sda));
    if (!scl_lo && p_scl) begin
      if (rel > 0) check(lo_len == H, "R2", "low phase length", lo_len, H);
      if (rel < 16) bits[rel] = ~(sda_lo | slave_low);
      rises++;
      hi_len = 1;
      in_hi = 1;
    end else if (scl_lo && !p_scl) begin
      if (in_hi) check(hi_len == H, "R2", "high phase length", hi_len, H);
      in_hi = 0;
      lo_len = 1;
      if (mode_rx) slave_low = (rel < 8) ? ~rx_byte[7 - rel] : 1'b0;
      else         slave_low = (rel == 8) ? ack_low : 1'b0;
    end else if (scl_lo) lo_len++;
    else hi_len++;
    if (bf_p && !buf_full) begin
      bf_drop_rel = rises - base;
      bf_drop_scl = scl_lo;
    end
    p_scl = scl_lo;
    p_sda = sda_lo;
    bf_p  = buf_full;
  end

  task automatic wait_irq(input string req);
    int n = 0;
    while (!irq && n < 4000) begin @(negedge clk); n++; end
    check(irq == 1'b1, req, "irq after byte", int'(irq), 1);
  endtask

  task automatic pulse_clr_irq();
    clr_irq = 1; @(negedge clk); clr_irq = 0;
    check(irq == 1'b0, "R12", "irq cleared", int'(irq), 0);
  endtask

  // poke: 0 none, 1 colliding write, 2 receive-enable while busy
  task automatic do_tx(input logic [7:0] b, input bit ackl, input int poke);
    logic [7:0] got;
    int r0;
    base = rises; mode_rx = 0; ack_low = ackl; slave_low = 0; bf_drop_rel = -1;
    wr_data = b; wr_stb = 1; @(negedge clk); wr_stb = 0;
    check(buf_full == 1'b1, "R2", "buf_full after write", int'(buf_full), 1);
    check(scl_lo == 1'b1, "R2", "SCL pulled after write", int'(scl_lo), 1);
    if (poke != 0) begin
      repeat (3 * H) @(negedge clk);
      if (poke == 1) begin
        wr_data = ~b; wr_stb = 1; @(negedge clk); wr_stb = 0;
        check(wcol == 1'b1, "R7", "wcol on busy write", int'(wcol), 1);
        check(rd_data == b, "R7", "buffer unchanged", int'(rd_data), int'(b));
      end else begin
        rx_go = 1; @(negedge clk); rx_go = 0;
        check(rx_en == 1'b0, "R11", "rx_go ignored in transmit", int'(rx_en), 0);
      end
    end
    wait_irq("R6");
    for (int i = 0; i < 8; i++) got[7 - i] = bits[i];
    check(rises - base == 9, "R2", "pulses per transmit", rises - base, 9);
    check(got == b, "R3", "bits on SDA MSB first", int'(got), int'(b));
    check(bf_drop_rel == 8 && bf_drop_scl, "R4", "buf_full drop at 8th fall", bf_drop_rel, 8);
    check(bits[8] == !ackl, "R4", "SDA released in ninth pulse", int'(bits[8]), int'(!ackl));
    check(ack_stat == !ackl, "R5", "ack_stat", int'(ack_stat), int'(!ackl));
    check(scl_lo && !sda_lo, "R6", "stall SCL low SDA released", int'({scl_lo, sda_lo}), 2);
    r0 = rises;
    repeat (3 * H) @(negedge clk);
    check(rises == r0 && scl_lo, "R6", "no pulses while stalled", rises - r0, 0);
    if (poke == 1) check(wcol == 1'b1, "R7", "wcol sticky", int'(wcol), 1);
    if (poke == 2) check(rx_en == 1'b0, "R11", "no receive after ignored rx_go", int'(rx_en), 0);
    pulse_clr_irq();
  endtask

  task automatic do_rx(input logic [7:0] b, input bit read_first, input bit poke);
    bit bfb, ovb;
    logic [7:0] old;
    if (read_first) begin
      rd_stb = 1; @(negedge clk); rd_stb = 0;
      check(buf_full == 1'b0, "R9", "read clears buf_full", int'(buf_full), 0);
    end
    bfb = buf_full; ovb = ovf; old = rd_data;
    base = rises; mode_rx = 1; rx_byte = b; slave_low = ~b[7];
    rx_go = 1; @(negedge clk); rx_go = 0;
    check(rx_en == 1'b1, "R8", "rx_en after rx_go", int'(rx_en), 1);
    if (poke) begin
      repeat (2 * H) @(negedge clk);
      wr_data = ~old; wr_stb = 1; @(negedge clk); wr_stb = 0;
      check(wcol == 1'b1, "R7", "wcol during receive", int'(wcol), 1);
      check(rd_data == old, "R7", "buffer unchanged in receive", int'(rd_data), int'(old));
    end
    wait_irq("R8");
    check(rises - base == 8, "R8", "pulses per receive", rises - base, 8);
    check(rd_data == b, "R8", "received byte", int'(rd_data), int'(b));
    check(!rx_en && buf_full, "R8", "rx_en low, buf_full high", int'({rx_en, buf_full}), 1);
    check(ovf == (ovb | bfb), "R10", "overflow flag", int'(ovf), int'(ovb | bfb));
    check(scl_lo && !sda_lo, "R6", "stall after receive", int'({scl_lo, sda_lo}), 2);
    slave_low = 0;
    pulse_clr_irq();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check({scl_lo, sda_lo, buf_full, wcol, ovf, ack_stat, irq, rx_en} == 8'h0,
          "R1", "reset state", int'({scl_lo, sda_lo, buf_full, wcol, ovf, ack_stat, irq, rx_en}), 0);

    do_tx(8'hA5, 1, 0);
    do_tx(8'h3C, 0, 0);
    do_tx(8'h81, 1, 1);
    clr_wcol = 1; @(negedge clk); clr_wcol = 0;
    check(wcol == 1'b0, "R7", "wcol cleared", int'(wcol), 0);
    do_tx(8'h00, 0, 2);
    do_tx(8'hFF, 1, 0);

    do_rx(8'h5A, 1, 0);
    do_rx(8'hC3, 0, 0);
    rd_stb = 1; @(negedge clk); rd_stb = 0;
    check(ovf == 1'b1, "R10", "ovf sticky after read", int'(ovf), 1);
    clr_ovf = 1; @(negedge clk); clr_ovf = 0;
    check(ovf == 1'b0, "R10", "ovf cleared", int'(ovf), 0);
    do_rx(8'h0F, 1, 1);
    clr_wcol = 1; @(negedge clk); clr_wcol = 0;
    do_rx(8'h80, 1, 0);

    for (int k = 0; k < 24; k++) begin
      logic [7:0] b;
      b = 8'($urandom);
      if ($urandom % 3 == 0) begin clr_ovf = 1; @(negedge clk); clr_ovf = 0; end
      if ($urandom % 2 == 0) do_tx(b, 1'($urandom), 0);
      else                   do_rx(b, 1'($urandom), 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule